// File: doc/BRIEF.md
# Translation Unit Control and Fault Register Block

This block is the software-facing control plane of a paging address translator. It decodes a plain word-addressed register read/write port and holds the translation directory base, the pending-command state, the interrupt status and mask, and the faulting virtual address. Software starts a command by writing a code to the command register. Paging and stall changes finish after a fixed number of cycles, and software watches a status word until the change has taken effect.

On the walker side the block drives the paging enable and stall request levels, together with one-cycle pulses that flush the whole translation cache or one line of it. It takes in a fault pulse with its virtual address and a bus-error pulse. A page fault freezes the translator. The freeze lasts until software has flushed the cache and then issued a fault-done command. The interrupt line is the OR of the sticky interrupt bits that the mask lets through.

Top module: `xlat_ctl_regs`

## Requirements
- R1: The directory base register (word 0) resets to zero and reads back exactly the last value written.
- R2: Command code 0 turns paging on and code 1 turns it off. The change lands CMD_LAT cycles after the write. Until then, status bit 0 and the `paging_en` port keep their old value.
- R3: Command code 2 enters stall and code 3 leaves it, with the same latency. Status bit 1 shows the stall state, and `stall_req` is high while stall is active.
- R4: Command code 4 forces a reset. CMD_LAT cycles after the write the directory base reads zero and paging is off. Before that the base keeps its value.
- R5: Status bit 3 is high while a latency command is pending. Any code from 0 to 4 written during that time is dropped. Codes 7 to 15 have no effect at any time.
- R6: Command code 5 gives a one-cycle `flush_all` pulse in the cycle after the write. A write to word 4 gives a one-cycle `flush_line` pulse, with `flush_va` equal to the data written.
- R7: If a fault pulse arrives while no fault is held, it does three things: it sets interrupt status bit 0 (word 5), it stores its address in word 3, and it holds the translator, so status bit 2 and `stall_req` go high. A fault that arrives while one is already held changes nothing.
- R8: The hold is released only by command code 6 that follows a code 5 flush issued while the hold was active. A code 6 issued before any such flush is ignored.
- R9: A bus-error pulse sets interrupt status bit 1 and does not hold the translator.
- R10: Interrupt status bits stay set until a write to word 6 with a one in their position clears them. If a new event arrives on the same cycle as the clear, the event wins.
- R11: `irq` is the OR of the interrupt status ANDed with the mask (word 7, bits 1:0). A zero mask keeps `irq` low.
- R12: Word addresses 8 to 15 read as zero and ignore writes. The command, line-flush and clear words (2, 4, 6) read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from reg_addr |
| paging_en | output | 1 | Translation enabled |
| stall_req | output | 1 | Stall request to the translator (stall state or held fault) |
| flush_all | output | 1 | One-cycle whole-cache flush |
| flush_line | output | 1 | One-cycle single-line flush |
| flush_va | output | DATA_W | Virtual address for the line flush |
| walk_fault | input | 1 | Page-fault pulse from the walker |
| walk_fault_va | input | DATA_W | Faulting virtual address |
| walk_bus_err | input | 1 | Bus-error pulse from the walker |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check four things: that status flags stay frozen while a command is pending, that the directory base is zero after a forced reset, that a held fault keeps its address and asserts the stall request, and that an interrupt bit falls only on a matching clear write with the mask gating `irq`. The bench scenarios are needed for the exact completion cycle of each latency command, the dropping of commands during busy and of unknown codes, and the release order of the fault hold (flush first, then fault-done). They also sweep every status and mask combination against `irq`, and every word address for read-as-zero.

// File: rtl/xlat_ctl_pkg.sv
// Shared encodings for the translation control register block.
// Assumes a word-addressed register port; the low three address bits pick a register.
package xlat_ctl_pkg;
    localparam int CMD_W     = 4;
    localparam int REG_IDX_W = 3;
    localparam int IRQ_N     = 2;

    typedef enum logic [CMD_W-1:0] {
        CMD_PG_ON      = 4'd0,
        CMD_PG_OFF     = 4'd1,
        CMD_STALL_ON   = 4'd2,
        CMD_STALL_OFF  = 4'd3,
        CMD_FORCE_RST  = 4'd4,
        CMD_FLUSH_ALL  = 4'd5,
        CMD_FAULT_DONE = 4'd6
    } xlat_cmd_e;

    localparam logic [REG_IDX_W-1:0] REG_DIR   = 3'd0;
    localparam logic [REG_IDX_W-1:0] REG_STAT  = 3'd1;
    localparam logic [REG_IDX_W-1:0] REG_CMD   = 3'd2;
    localparam logic [REG_IDX_W-1:0] REG_FADDR = 3'd3;
    localparam logic [REG_IDX_W-1:0] REG_LINE  = 3'd4;
    localparam logic [REG_IDX_W-1:0] REG_ISTAT = 3'd5;
    localparam logic [REG_IDX_W-1:0] REG_ICLR  = 3'd6;
    localparam logic [REG_IDX_W-1:0] REG_IMASK = 3'd7;

    localparam int IRQ_PF  = 0;
    localparam int IRQ_BUS = 1;

    localparam int ST_PAGING = 0;
    localparam int ST_STALL  = 1;
    localparam int ST_HELD   = 2;
    localparam int ST_BUSY   = 3;
endpackage

// File: rtl/xlat_cmd_seq.sv
// Command sequencer: paging/stall/force-reset commands complete after CMD_LAT
// cycles. Flush-all and fault-done take effect at once.
// Assumes CMD_LAT >= 1. Slow commands written while one is pending are dropped.
module xlat_cmd_seq
    import xlat_ctl_pkg::*;
#(
    parameter int CMD_LAT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_code,
    output logic             paging_on,
    output logic             stall_on,
    output logic             busy,
    output logic             rst_done,
    output logic             flush_req,
    output logic             fault_done_req,
    output logic             flush_all_q
);
    localparam int CNT_W = (CMD_LAT > 1) ? $clog2(CMD_LAT) : 1;

    logic [CNT_W-1:0] cnt;
    logic [CMD_W-1:0] pend_code;
    logic             is_slow;
    logic             accept;
    logic             finish;

    // Classify the written code as a latency command
    always_comb begin
        is_slow = (cmd_code == CMD_PG_ON)    || (cmd_code == CMD_PG_OFF) ||
                  (cmd_code == CMD_STALL_ON) || (cmd_code == CMD_STALL_OFF) ||
                  (cmd_code == CMD_FORCE_RST);
    end

    assign accept         = cmd_wr && is_slow && !busy;
    assign finish         = busy && (cnt == '0);
    assign rst_done       = finish && (pend_code == CMD_FORCE_RST);
    assign flush_req      = cmd_wr && (cmd_code == CMD_FLUSH_ALL);
    assign fault_done_req = cmd_wr && (cmd_code == CMD_FAULT_DONE);

    // Track the pending command and count down its latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            cnt       <= '0;
            pend_code <= '0;
        end else if (accept) begin
            busy      <= 1'b1;
            pend_code <= cmd_code;
            cnt       <= CNT_W'(CMD_LAT - 1);
        end else if (finish) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Apply the pending command's effect on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paging_on <= 1'b0;
            stall_on  <= 1'b0;
        end else if (finish) begin
            case (pend_code)
                CMD_PG_ON:     paging_on <= 1'b1;
                CMD_PG_OFF:    paging_on <= 1'b0;
                CMD_STALL_ON:  stall_on  <= 1'b1;
                CMD_STALL_OFF: stall_on  <= 1'b0;
                CMD_FORCE_RST: paging_on <= 1'b0;
                default:       ;
            endcase
        end
    end

    // Register the whole-cache flush pulse for the walker
    always_ff @(posedge clk) begin
        if (!rst_n) flush_all_q <= 1'b0;
        else        flush_all_q <= flush_req;
    end
endmodule

// File: rtl/xlat_fault_irq.sv
// Fault capture, translator hold, sticky interrupt bits and interrupt output.
// Assumes one fault is handled at a time; faults arriving while held are dropped.
module xlat_fault_irq
    import xlat_ctl_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_in,
    input  logic [DATA_W-1:0] fault_va,
    input  logic              bus_err_in,
    input  logic              clr_wr,
    input  logic [IRQ_N-1:0]  clr_bits,
    input  logic              flush_req,
    input  logic              fault_done_req,
    input  logic [IRQ_N-1:0]  int_mask,
    output logic [IRQ_N-1:0]  int_status,
    output logic [DATA_W-1:0] fault_addr,
    output logic              fault_hold,
    output logic              irq
);
    logic             take_fault;
    logic             flushed;
    logic [IRQ_N-1:0] set_vec;

    assign take_fault       = fault_in && !fault_hold;
    assign set_vec[IRQ_PF]  = take_fault;
    assign set_vec[IRQ_BUS] = bus_err_in;

    // One sticky bit per interrupt source; a new event beats a clear
    for (genvar g = 0; g < IRQ_N; g++) begin : g_sticky
        always_ff @(posedge clk) begin
            if (!rst_n)                      int_status[g] <= 1'b0;
            else if (set_vec[g])             int_status[g] <= 1'b1;
            else if (clr_wr && clr_bits[g])  int_status[g] <= 1'b0;
        end
    end

    // Hold the translator from fault capture until flush then fault-done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_hold <= 1'b0;
            flushed    <= 1'b0;
            fault_addr <= '0;
        end else if (take_fault) begin
            fault_hold <= 1'b1;
            flushed    <= 1'b0;
            fault_addr <= fault_va;
        end else if (fault_hold) begin
            if (fault_done_req && flushed) begin
                fault_hold <= 1'b0;
                flushed    <= 1'b0;
            end else if (flush_req) begin
                flushed <= 1'b1;
            end
        end
    end

    assign irq = |(int_status & int_mask);
endmodule

// File: rtl/xlat_ctl_regs.sv
// Top of the translation control register block: address decode, directory
// base, interrupt mask, line flush and read mux around the sequencer and fault unit.
// Assumes ADDR_W >= 3; words at or above 8 are unmapped.
module xlat_ctl_regs
    import xlat_ctl_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int CMD_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              paging_en,
    output logic              stall_req,
    output logic              flush_all,
    output logic              flush_line,
    output logic [DATA_W-1:0] flush_va,
    input  logic              walk_fault,
    input  logic [DATA_W-1:0] walk_fault_va,
    input  logic              walk_bus_err,
    output logic              irq
);
    localparam int HI_W = (ADDR_W > REG_IDX_W) ? ADDR_W - REG_IDX_W : 1;

    logic                 in_map;
    logic [REG_IDX_W-1:0] idx;
    logic                 wr_dir, wr_cmd, wr_line, wr_clr, wr_mask;
    logic [DATA_W-1:0]    dir_base;
    logic [IRQ_N-1:0]     int_mask;
    logic [IRQ_N-1:0]     int_status;
    logic [DATA_W-1:0]    fault_addr;
    logic                 fault_hold;
    logic                 paging_on, stall_on, busy, rst_done;
    logic                 flush_req, fault_done_req;

    // Split the word address into map select and register index
    generate
        if (ADDR_W > REG_IDX_W) begin : g_hi
            assign in_map = (reg_addr[ADDR_W-1:REG_IDX_W] == HI_W'(0));
        end else begin : g_nohi
            assign in_map = 1'b1;
        end
    endgenerate
    assign idx = reg_addr[REG_IDX_W-1:0];

    // Decode write strobes per register
    always_comb begin
        wr_dir  = reg_wr && in_map && (idx == REG_DIR);
        wr_cmd  = reg_wr && in_map && (idx == REG_CMD);
        wr_line = reg_wr && in_map && (idx == REG_LINE);
        wr_clr  = reg_wr && in_map && (idx == REG_ICLR);
        wr_mask = reg_wr && in_map && (idx == REG_IMASK);
    end

    // Directory base: software writable, zeroed by forced reset completion
    always_ff @(posedge clk) begin
        if (!rst_n)        dir_base <= '0;
        else if (rst_done) dir_base <= '0;
        else if (wr_dir)   dir_base <= reg_wdata;
    end

    // Interrupt mask register
    always_ff @(posedge clk) begin
        if (!rst_n)       int_mask <= '0;
        else if (wr_mask) int_mask <= reg_wdata[IRQ_N-1:0];
    end

    // Single-line flush pulse and its address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_line <= 1'b0;
            flush_va   <= '0;
        end else begin
            flush_line <= wr_line;
            if (wr_line) flush_va <= reg_wdata;
        end
    end

    xlat_cmd_seq #(
        .CMD_LAT(CMD_LAT)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_wr        (wr_cmd),
        .cmd_code      (reg_wdata[CMD_W-1:0]),
        .paging_on     (paging_on),
        .stall_on      (stall_on),
        .busy          (busy),
        .rst_done      (rst_done),
        .flush_req     (flush_req),
        .fault_done_req(fault_done_req),
        .flush_all_q   (flush_all)
    );

    xlat_fault_irq #(
        .DATA_W(DATA_W)
    ) u_fault (
        .clk           (clk),
        .rst_n         (rst_n),
        .fault_in      (walk_fault),
        .fault_va      (walk_fault_va),
        .bus_err_in    (walk_bus_err),
        .clr_wr        (wr_clr),
        .clr_bits      (reg_wdata[IRQ_N-1:0]),
        .flush_req     (flush_req),
        .fault_done_req(fault_done_req),
        .int_mask      (int_mask),
        .int_status    (int_status),
        .fault_addr    (fault_addr),
        .fault_hold    (fault_hold),
        .irq           (irq)
    );

    assign paging_en = paging_on;
    assign stall_req = stall_on || fault_hold;

    // Read mux; write-only and unmapped words return zero
    always_comb begin
        reg_rdata = '0;
        if (in_map) begin
            case (idx)
                REG_DIR:   reg_rdata = dir_base;
                REG_STAT: begin
                    reg_rdata[ST_PAGING] = paging_on;
                    reg_rdata[ST_STALL]  = stall_on;
                    reg_rdata[ST_HELD]   = fault_hold;
                    reg_rdata[ST_BUSY]   = busy;
                end
                REG_FADDR: reg_rdata = fault_addr;
                REG_ISTAT: reg_rdata[IRQ_N-1:0] = int_status;
                REG_IMASK: reg_rdata[IRQ_N-1:0] = int_mask;
                default:   reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/xlat_ctl_regs_chk.sv
// Assertion checker for the translation control register block, bound to its top.
module xlat_ctl_regs_chk
    import xlat_ctl_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              stall_req,
    input logic              irq,
    input logic              busy,
    input logic              paging_on,
    input logic              stall_on,
    input logic              rst_done,
    input logic [DATA_W-1:0] dir_base,
    input logic              fault_hold,
    input logic [DATA_W-1:0] fault_addr,
    input logic [IRQ_N-1:0]  int_status,
    input logic [IRQ_N-1:0]  int_mask
);
    p_paging_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $stable(paging_on));

    p_stall_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $stable(stall_on));

    p_base_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_done |=> (dir_base == '0));

    p_fault_addr_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_hold && $past(fault_hold)) |-> $stable(fault_addr));

    p_hold_stalls_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_hold |-> stall_req);

    p_sticky_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_status[IRQ_PF]) |->
            $past(reg_wr && (reg_addr == ADDR_W'(REG_ICLR)) && reg_wdata[IRQ_PF]));

    p_mask_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (int_mask == '0) |-> !irq);
endmodule

bind xlat_ctl_regs xlat_ctl_regs_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .stall_req (stall_req),
    .irq       (irq),
    .busy      (busy),
    .paging_on (paging_on),
    .stall_on  (stall_on),
    .rst_done  (rst_done),
    .dir_base  (dir_base),
    .fault_hold(fault_hold),
    .fault_addr(fault_addr),
    .int_status(int_status),
    .int_mask  (int_mask)
);

// File: tb/xlat_ctl_regs_bench.sv
// Self-checking bench: sweeps registers, command latencies, fault/irq combinations.
module xlat_ctl_regs_bench;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 32;
    localparam int LAT     = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              paging_en, stall_req, flush_all, flush_line, irq;
    logic [DATA_W-1:0] flush_va;
    logic              walk_fault = 1'b0;
    logic [DATA_W-1:0] walk_fault_va = '0;
    logic              walk_bus_err = 1'b0;

    int vecs = 0;
    int errs = 0;

    always #2 clk = ~clk;

    xlat_ctl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_LAT(LAT)) u_xlat_ctl_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .paging_en(paging_en),
        .stall_req(stall_req), .flush_all(flush_all), .flush_line(flush_line),
        .flush_va(flush_va), .walk_fault(walk_fault), .walk_fault_va(walk_fault_va),
        .walk_bus_err(walk_bus_err), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = ADDR_W'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic walker(input logic f, input logic b, input logic [31:0] va);
        @(negedge clk);
        walk_fault = f; walk_bus_err = b; walk_fault_va = va;
        @(negedge clk);
        walk_fault = 1'b0; walk_bus_err = 1'b0;
    endtask

    task automatic release_hold();
        wr(2, 32'd5);
        wr(2, 32'd6);
    endtask

    // Issue a latency command and follow the status bit cycle by cycle
    task automatic lat_cmd(input string req, input int code, input int bitn,
                           input logic oldv, input logic newv);
        logic [31:0] s;
        wr(2, code);
        for (int d = 0; d < LAT; d++) begin
            rd(1, s);
            check(req, 32'(s[bitn]), 32'(oldv));
            check({req, " busy R5"}, 32'(s[3]), 32'd1);
            check(req, 32'(bitn == 0 ? paging_en : stall_req), 32'(oldv));
            @(negedge clk);
        end
        rd(1, s);
        check(req, 32'(s[bitn]), 32'(newv));
        check({req, " busy R5"}, 32'(s[3]), 32'd0);
        check(req, 32'(bitn == 0 ? paging_en : stall_req), 32'(newv));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        vecs++; errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: all words after writes to unmapped words, all read zero
        for (int a = 8; a < 16; a++) wr(a, 32'hFFFF_FFFF);
        for (int a = 0; a < 16; a++) begin
            rd(a, r);
            check("R12 read zero", r, 32'h0);
        end
        check("R12 outputs idle", 32'({paging_en, stall_req, irq}), 32'h0);

        // R1: walking-one and pattern readback
        for (int i = 0; i < 32; i++) begin
            wr(0, 32'h1 << i);
            rd(0, r);
            check("R1 dir readback", r, 32'h1 << i);
        end
        wr(0, 32'hA5C3_5A3C);
        rd(0, r);
        check("R1 dir pattern", r, 32'hA5C3_5A3C);

        // R2, R3: latency of paging and stall changes
        lat_cmd("R2 paging on", 0, 0, 1'b0, 1'b1);
        lat_cmd("R3 stall on", 2, 1, 1'b0, 1'b1);
        lat_cmd("R3 stall off", 3, 1, 1'b1, 1'b0);
        lat_cmd("R2 paging off", 1, 0, 1'b1, 1'b0);

        // R5: command during busy is dropped, unknown codes ignored
        wr(2, 32'd0);
        wr(2, 32'd2);
        repeat (LAT + 2) @(negedge clk);
        rd(1, r);
        check("R5 dropped stall", 32'(r[1]), 32'd0);
        check("R5 paging landed", 32'(r[0]), 32'd1);
        for (int c = 7; c < 16; c++) wr(2, c);
        repeat (LAT + 2) @(negedge clk);
        rd(1, r);
        check("R5 unknown codes", r, 32'h1);
        check("R5 no flush", 32'(flush_all), 32'd0);

        // R4: forced reset clears base after latency, paging off
        wr(0, 32'h1234_5000);
        wr(2, 32'd4);
        for (int d = 0; d < LAT; d++) begin
            rd(0, r);
            check("R4 base held", r, 32'h1234_5000);
            @(negedge clk);
        end
        rd(0, r);
        check("R4 base zero", r, 32'h0);
        rd(1, r);
        check("R4 paging off", r, 32'h0);

        // R6: flush pulses
        wr(2, 32'd5);
        check("R6 flush_all pulse", 32'(flush_all), 32'd1);
        @(negedge clk);
        check("R6 flush_all single", 32'(flush_all), 32'd0);
        wr(4, 32'hDEAD_B000);
        check("R6 line pulse", 32'(flush_line), 32'd1);
        check("R6 line va", flush_va, 32'hDEAD_B000);
        @(negedge clk);
        check("R6 line single", 32'(flush_line), 32'd0);

        // R7, R8: fault capture, hold, release order
        walker(1'b1, 1'b0, 32'h4000_1234);
        rd(5, r); check("R7 pf status", r, 32'h1);
        rd(3, r); check("R7 fault addr", r, 32'h4000_1234);
        rd(1, r); check("R7 held bit", 32'(r[2]), 32'd1);
        check("R7 stall_req", 32'(stall_req), 32'd1);
        walker(1'b1, 1'b0, 32'h5000_0000);
        rd(3, r); check("R7 addr kept", r, 32'h4000_1234);
        wr(2, 32'd6);
        rd(1, r); check("R8 done w/o flush", 32'(r[2]), 32'd1);
        release_hold();
        rd(1, r); check("R8 released", 32'(r[2]), 32'd0);
        check("R8 stall_req low", 32'(stall_req), 32'd0);
        walker(1'b1, 1'b0, 32'h5000_0000);
        rd(3, r); check("R7 new fault addr", r, 32'h5000_0000);
        release_hold();

        // R10: clear and set-wins
        wr(6, 32'd1);
        rd(5, r); check("R10 clear pf", r, 32'h0);
        walker(1'b0, 1'b1, 32'h0);
        rd(5, r); check("R9 bus status", r, 32'h2);
        rd(1, r); check("R9 no hold", 32'(r[2]), 32'd0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd6; reg_wdata = 32'd2; walk_bus_err = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; walk_bus_err = 1'b0;
        rd(5, r); check("R10 set wins", r, 32'h2);
        walker(1'b1, 1'b0, 32'h0);
        wr(6, 32'd2);
        rd(5, r); check("R10 partial clear", r, 32'h1);
        release_hold();
        wr(6, 32'd3);
        rd(5, r); check("R10 clear all", r, 32'h0);

        // R11: irq over every status and mask combination
        for (int s = 0; s < 4; s++) begin
            for (int m = 0; m < 4; m++) begin
                wr(6, 32'd3);
                walker(s[0], s[1], 32'h0);
                wr(7, m);
                rd(7, r); check("R11 mask readback", r, 32'(m));
                check("R11 irq", 32'(irq), 32'(((s & m) != 0) ? 1 : 0));
                release_hold();
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule